// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable, reduced-depth model of a clocked SRAM. Each word holds 18 bits as two 9-bit bytes. Byte a is bits 8:0 and byte b is bits 17:9. Address and controls are captured on the rising clock edge. A load strobe starts an access at a new address. An advance strobe steps through a four-beat burst inside the aligned group of four words. A strap selects how the beats are ordered: XOR-interleaved or wrapping linear.

A global write strobe writes the whole word. Otherwise, a byte-write enable together with one strobe per byte chooses which bytes are written. Any other combination is a read. Read data leaves through an output register one clock after the access edge. An asynchronous output-enable and a sleep input can both force the output driver off. The bus is split into an input half and an output half, and an output-drive flag marks when the output half is driven. While sleep is high, the block ignores every other control.

Top module: `ssram_burst`

## Requirements
- R1: An access with `gw_ni` low writes both bytes of the word, whatever `bwe_ni` and `bw_ni` are.
- R2: An access with `gw_ni` high and `bwe_ni` low writes each byte whose `bw_ni` bit is low (bit 0 selects byte a, bits 8:0; bit 1 selects byte b, bits 17:9). A byte whose strobe is high keeps its value.
- R3: An access with `gw_ni` high and either `bwe_ni` high or `bw_ni` equal to 2'b11 is a read, and it changes no stored byte.
- R4: A read access presents the stored word on `dq_o`, with `dq_oe_o` high (while `oe_ni` is low), in the cycle after its clock edge.
- R5: With `burst_xor_i` high, beat k (k = 0..3) accesses low address bits equal to the start bits XOR k. For example, start 01 gives 01, 00, 11, 10.
- R6: With `burst_xor_i` low, beat k accesses the start bits plus k, modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R7: The address bits above bit 1 stay fixed for the whole burst. An advance after the fourth beat returns to the first beat's address.
- R8: While `sleep_i` is high, nothing is written, the loaded address and beat position do not change, and `dq_oe_o` is low.
- R9: `dq_oe_o` is low in any cycle where `oe_ni` is high, with no clock needed. It is also low in the cycle after a write edge.
- R10: After reset, `dq_oe_o` is low.
- R11: A cycle with neither `addr_load_i` nor `adv_i` performs no access. It holds the beat position, and `dq_oe_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Snooze; overrides all controls |
| burst_xor_i | input | 1 | Burst order strap: 1 = XOR-interleaved, 0 = linear wrap |
| addr_load_i | input | 1 | Load a new address and start at beat 0 |
| adv_i | input | 1 | Step to the next burst beat |
| addr_i | input | ADDR_W | Word address |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | NB | Per-byte write strobes, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | NB*BYTE_W | Write data |
| dq_o | output | NB*BYTE_W | Read data from the output register |
| dq_oe_o | output | 1 | Output half of the bus is driven |

## Verification
Two things can land in the same cycle. One is a pending read result reaching the output. The other is a sleep or output-disable that must suppress it. The bench creates this overlap by issuing a read and then, on the very next cycle, raising `sleep_i` or `oe_ni`. The scoreboard's expected drive state for that read is the read flag ANDed with the control levels of the cycle in which it emerges. A second overlap is a sleep cycle that falls inside a burst while it carries a load and a write. It is judged by the data returned on the next advance and by a later read of the targeted address.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  // low two address bits for a burst beat
  function automatic logic [1:0] beat_addr(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       xor_mode);
    logic [1:0] r;
    if (xor_mode) r = start ^ cnt;
    else          r = start + cnt;
    return r;
  endfunction
endpackage

// File: rtl/ssram_burst_ctr.sv
module ssram_burst_ctr
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              xor_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_n;
  logic [1:0]        start;
  logic [HI_W-1:0]   hi;

  always_comb begin
    if (load_i)     cnt_n = 2'd0;
    else if (adv_i) cnt_n = cnt_q + 2'd1;
    else            cnt_n = cnt_q;
    start      = load_i ? addr_i[1:0] : base_q[1:0];
    hi         = load_i ? addr_i[ADDR_W-1:2] : base_q[ADDR_W-1:2];
    acc_addr_o = {hi, beat_addr(start, cnt_n, xor_mode_i)};
    acc_o      = !sleep_i && (load_i || adv_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!sleep_i) begin
      if (load_i) base_q <= addr_i;
      cnt_q <= cnt_n;
    end
  end

  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(base_q) && $stable(cnt_q))); // R8
  AST_BURST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !load_i && cnt_q == 2'd3) |-> (acc_addr_o == base_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode #(
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  output logic [NB-1:0] we_o,
  output logic          rd_o
);
  for (genvar b = 0; b < NB; b++) begin : g_be
    assign we_o[b] = acc_i & (~gw_ni | (~bwe_ni & ~bw_ni[b]));
  end
  assign rd_o = acc_i & ~(|we_o);

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && (|we_o))); // R3
  AST_GLOBAL_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !gw_ni) |-> !rd_o); // R1
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int ADDR_W = 6,
  parameter int NB     = 2,
  parameter int BYTE_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NB-1:0]        we_i,
  input  logic                 rd_i,
  input  logic [NB*BYTE_W-1:0] wdata_i,
  output logic [NB*BYTE_W-1:0] rdata_o,
  output logic                 rvld_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[b]) mem_q[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      if (rd_i)    rd_q <= mem_q[addr_i];
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvld_o <= 1'b0;
    else         rvld_o <= rd_i;
  end

  AST_RD_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvld_o); // R4
  AST_WR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_i) |=> !rvld_o); // R9
endmodule

// File: rtl/ssram_burst.sv
module ssram_burst #(
  parameter int ADDR_W = 6,
  parameter int NB     = 2,
  parameter int BYTE_W = 9,
  localparam int DW    = NB * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              burst_xor_i,
  input  logic              addr_load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [NB-1:0]     bw_ni,
  input  logic              oe_ni,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic [NB-1:0]     we;
  logic              rd;
  logic              rvld;

  ssram_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk_i, .rst_ni, .sleep_i,
    .load_i     (addr_load_i),
    .adv_i,
    .xor_mode_i (burst_xor_i),
    .addr_i,
    .acc_o      (acc),
    .acc_addr_o (acc_addr)
  );

  ssram_wr_decode #(.NB(NB)) i_dec (
    .clk_i, .rst_ni,
    .acc_i  (acc),
    .gw_ni, .bwe_ni, .bw_ni,
    .we_o   (we),
    .rd_o   (rd)
  );

  ssram_array #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) i_arr (
    .clk_i, .rst_ni,
    .addr_i  (acc_addr),
    .we_i    (we),
    .rd_i    (rd),
    .wdata_i (dq_i),
    .rdata_o (dq_o),
    .rvld_o  (rvld)
  );

  // output drive is asynchronous in oe_ni and sleep_i
  assign dq_oe_o = rvld & ~oe_ni & ~sleep_i;

  AST_SLEEP_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o); // R8
  AST_OE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R9
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (we == '0)); // R8
endmodule

// File: tb/test_ssram_burst.sv
`timescale 1ns/1ps
module test_ssram_burst;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 1'b0, burst_xor = 1'b0, ld = 1'b0, adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic gw_ni = 1'b1, bwe_ni = 1'b1, oe_ni = 1'b0;
  logic [1:0] bw_ni = 2'b11;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;

  always #2 clk = ~clk;

  ssram_burst i_ssram_burst (
    .clk_i(clk), .rst_ni, .sleep_i, .burst_xor_i(burst_xor),
    .addr_load_i(ld), .adv_i(adv), .addr_i(addr),
    .gw_ni, .bwe_ni, .bw_ni, .oe_ni, .dq_i, .dq_o, .dq_oe_o
  );

  typedef struct {
    int            due;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] model [64];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: applies one cycle of controls and updates the reference model
  task automatic drive(input bit l, input bit a_v, input logic [AW-1:0] a,
                       input bit gw, input bit bwe, input logic [1:0] bw,
                       input logic [DW-1:0] d, input bit oe, input bit slp,
                       input string req);
    logic [AW-1:0] acc;
    @(posedge clk); #1;
    ld = l; adv = a_v; addr = a; gw_ni = gw; bwe_ni = bwe; bw_ni = bw;
    dq_i = d; oe_ni = oe; sleep_i = slp;
    if (!slp && (l || a_v)) begin
      if (l) begin m_base = a; m_cnt = 2'd0; end
      else   m_cnt = m_cnt + 2'd1;
      acc = {m_base[AW-1:2], burst_xor ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      if (!gw) model[acc] = d;
      else if (!bwe && bw != 2'b11) begin
        if (!bw[0]) model[acc][8:0]  = d[8:0];
        if (!bw[1]) model[acc][17:9] = d[17:9];
      end else begin
        q.push_back('{cyc + 1, model[acc], req});
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, '0, 1, 1, 2'b11, '0, 0, 0, "R11");
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    drive(1, 0, a, 0, 1, 2'b11, d, 0, 0, req);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string req);
    drive(1, 0, a, 1, 1, 2'b11, '0, 0, 0, req);
  endtask
  task automatic rd_adv(input string req);
    drive(0, 1, '0, 1, 1, 2'b11, '0, 0, 0, req);
  endtask

  // monitor: compares the output against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        bit on;
        e  = q.pop_front();
        on = !oe_ni && !sleep_i;
        check(e.req, {31'd0, dq_oe_o}, {31'd0, on});
        if (on) check(e.req, {14'd0, dq_o}, {14'd0, e.d});
      end else begin
        check("R11", {31'd0, dq_oe_o}, 32'd0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] pat;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {31'd0, dq_oe_o}, 32'd0);
    rst_ni = 1'b1;
    idle(2);

    // fill memory with address-derived data
    for (int a = 0; a < 64; a++) wr(a[AW-1:0], 18'h2A5A5 ^ (a[17:0] * 18'h0137), "R1");
    for (int a = 0; a < 64; a += 9) rd(a[AW-1:0], "R1");
    idle(1);

    // R1: global write overrides byte strobes
    drive(1, 0, 6'h05, 0, 0, 2'b11, 18'h3C0F0, 0, 0, "R1");
    drive(1, 0, 6'h06, 0, 1, 2'b00, 18'h00FFF, 0, 0, "R1");
    rd(6'h05, "R1"); rd(6'h06, "R1");
    idle(1);

    // R2 / R3: every byte-strobe combination
    for (int b = 0; b < 4; b++) begin
      wr(6'h09, 18'h3FFFF, "R2");
      pat = 18'h1A2B3 + b[17:0];
      drive(1, 0, 6'h09, 1, 0, b[1:0], pat, 0, 0, (b == 3) ? "R3" : "R2");
      rd(6'h09, (b == 3) ? "R3" : "R2");
      idle(1);
    end
    // R3: byte-write enable high makes a read even with strobes low
    drive(1, 0, 6'h0A, 1, 1, 2'b00, 18'h15555, 0, 0, "R3");
    rd(6'h0A, "R3");
    idle(1);

    // R5 / R6 / R7: both orders from all four starting offsets
    for (int xm = 0; xm < 2; xm++) begin
      burst_xor = xm[0];
      for (int s = 0; s < 4; s++) begin
        rd({4'(5 + xm * 4 + s), s[1:0]}, xm ? "R5" : "R6");
        rd_adv(xm ? "R5" : "R6");
        rd_adv(xm ? "R5" : "R6");
        rd_adv(xm ? "R5" : "R6");
        rd_adv("R7");
        idle(1);
      end
    end

    // R5: burst write in interleaved order, read back singly
    burst_xor = 1'b1;
    drive(1, 0, 6'h2E, 0, 1, 2'b11, 18'h11111, 0, 0, "R5");
    drive(0, 1, '0,    0, 1, 2'b11, 18'h22222, 0, 0, "R5");
    drive(0, 1, '0,    0, 1, 2'b11, 18'h33333, 0, 0, "R5");
    drive(0, 1, '0,    0, 1, 2'b11, 18'h04444, 0, 0, "R5");
    for (int a = 44; a < 48; a++) rd(a[AW-1:0], "R5");
    rd(6'h2B, "R7"); rd(6'h30, "R7");
    idle(1);

    // R11: idle cycle inside a burst holds the beat
    burst_xor = 1'b0;
    rd(6'h15, "R11");
    idle(1);
    rd_adv("R11");
    idle(1);

    // R8: sleep mid-burst with a load and write attempt
    rd(6'h11, "R8");
    drive(1, 0, 6'h20, 0, 0, 2'b00, 18'h3FFFF, 0, 1, "R8");
    rd_adv("R8");
    rd(6'h20, "R8");
    idle(1);

    // R9: output enable high suppresses the pending read
    rd(6'h07, "R9");
    drive(0, 0, '0, 1, 1, 2'b11, '0, 1, 0, "R9");
    // R9: write right after a read, then bus released
    rd(6'h08, "R9");
    wr(6'h08, 18'h0ABCD, "R9");
    idle(1);
    rd(6'h08, "R9");
    idle(3);

    check("R4", q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule